// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the sampled values of a small general-purpose input port into interrupt requests. Each pin is configured on its own. It can be enabled or disabled, masked or unmasked, and set to trigger on a level or on an edge. A polarity bit picks the active level, or the direction of the active edge. Edge events are held in a per-pin pending flop until software sends a one-cycle clear pulse for that pin. Level events follow the pin for as long as the pin stays at its active level.

The pin values arrive already synchronized. The configuration vectors come from a register file outside the block and are treated as plain inputs. A single control bit decides whether level-type sources pass through one register stage before they reach the status outputs, or reach them combinationally. The block drives three outputs: a raw status that ignores the mask, a final status that honours it, and one combined interrupt line for the interrupt controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: With type bit 1 (edge) and polarity 1, a 0-to-1 change between two consecutive sampled pin values sets that pin's pending bit. With polarity 0, a 1-to-0 change sets it. A change in the other direction sets nothing. The pending bit appears on raw_status one clock after the edge at which the change was sampled.
- R2: An edge pending bit stays set until a clock edge at which the matching eoi_pulse bit is 1. It reads 0 from the following cycle on.
- R3: If an active edge is sampled at the same clock edge as that pin's eoi_pulse bit, the pending bit stays set.
- R4: With type bit 0 (level) and cfg_level_sync 0, raw_status follows the pin combinationally. It is 1 while the pin is high when polarity is 1, and 1 while the pin is low when polarity is 0. eoi_pulse has no effect on level-type pins.
- R5: With cfg_level_sync 1, a level-type pin's raw_status shows the active-level value that was captured at the previous clock edge.
- R6: A pin whose enable bit is 0 reads 0 on raw_status. A clock edge at which the enable bit is 0, or at which the pin is level-type, discards any pending edge of that pin.
- R7: raw_status ignores cfg_mask. final_status is raw_status with every bit whose mask bit is 1 forced to 0.
- R8: irq_out is 1 exactly when at least one final_status bit is 1.
- R9: A clock edge with rst high clears all pending bits, the level-sync register and the edge history. The first clock edge after reset only records the pin values, so a pin that is already at its active level after reset does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | Synchronized pin values |
| cfg_enable | input | 8 | Per-pin interrupt enable |
| cfg_mask | input | 8 | Per-pin mask, 1 hides the pin from final_status |
| cfg_is_edge | input | 8 | Per-pin trigger type, 1 edge, 0 level |
| cfg_polarity | input | 8 | Per-pin polarity, 1 high or rising, 0 low or falling |
| cfg_level_sync | input | 1 | 1 registers level-type sources before the status outputs |
| eoi_pulse | input | 8 | One-cycle per-pin clear of pending edges |
| raw_status | output | 8 | Unmasked interrupt status |
| final_status | output | 8 | Masked interrupt status |
| irq_out | output | 1 | OR of final_status |

## Verification
A wrong pending bit can only be seen on raw_status, so the stimulus sets pending bits, clears them, and triggers a set and a clear on the same edge. Each of these is checked one cycle after the clock edge that caused it, and a lost or stuck bit shows up in that very cycle. A wrong level-sync register or stale edge history shows up as a one-cycle shift: a level bit that arrives a cycle late or early, or a spurious pending bit in the cycle after reset. Checks are made in the middle of each cycle, after the inputs have changed and before the next edge, which tells combinational level paths apart from registered ones.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_kind_e;

    typedef struct packed {
        logic       enable;
        logic       mask;
        trig_kind_e kind;
        logic       active_high;
    } pin_cfg_t;

    function automatic logic level_is_active(input logic pin, input logic active_high);
        return ~(pin ^ active_high);
    endfunction

    function automatic logic edge_is_active(input logic now_v, input logic prev_v,
                                            input logic active_high);
        return active_high ? (now_v & ~prev_v) : (~now_v & prev_v);
    endfunction

endpackage

// File: rtl/gpio_pin_history.sv
module gpio_pin_history #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_now,
    output logic [WIDTH-1:0] pin_prev,
    output logic             prev_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev   <= '0;
            prev_valid <= 1'b0;
        end else begin
            pin_prev   <= pin_now;
            prev_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     level_sync,
    input  logic     pin_now,
    input  logic     pin_prev,
    input  logic     prev_valid,
    input  logic     eoi,
    output logic     raw
);
    logic pend_q;
    logic lvl_q;
    logic active_lvl;
    logic hit;
    logic is_edge;
    logic level_src;

    assign is_edge    = (cfg.kind == TRIG_EDGE);
    assign active_lvl = level_is_active(pin_now, cfg.active_high);
    assign hit        = prev_valid & cfg.enable & is_edge
                      & edge_is_active(pin_now, pin_prev, cfg.active_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            pend_q <= ((pend_q & ~eoi) | hit) & cfg.enable & is_edge;
            lvl_q  <= active_lvl;
        end
    end

    assign level_src = level_sync ? lvl_q : active_lvl;
    assign raw       = cfg.enable & (is_edge ? pend_q : level_src);
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] final_v,
    output logic             any
);
    assign final_v = raw & ~mask;
    assign any     = |final_v;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] cfg_enable,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic [NUM_PINS-1:0] cfg_is_edge,
    input  logic [NUM_PINS-1:0] cfg_polarity,
    input  logic                cfg_level_sync,
    input  logic [NUM_PINS-1:0] eoi_pulse,
    output logic [NUM_PINS-1:0] raw_status,
    output logic [NUM_PINS-1:0] final_status,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] pin_prev;
    logic                prev_valid;
    pin_cfg_t            pin_cfg [NUM_PINS];

    gpio_pin_history #(.WIDTH(NUM_PINS)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .pin_now    (pin_in),
        .pin_prev   (pin_prev),
        .prev_valid (prev_valid)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_cfg[i] = '{enable:      cfg_enable[i],
                              mask:        cfg_mask[i],
                              kind:        trig_kind_e'(cfg_is_edge[i]),
                              active_high: cfg_polarity[i]};

        gpio_irq_pin_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .cfg        (pin_cfg[i]),
            .level_sync (cfg_level_sync),
            .pin_now    (pin_in[i]),
            .pin_prev   (pin_prev[i]),
            .prev_valid (prev_valid),
            .eoi        (eoi_pulse[i]),
            .raw        (raw_status[i])
        );
    end

    gpio_irq_combine #(.WIDTH(NUM_PINS)) u_comb (
        .raw     (raw_status),
        .mask    (cfg_mask),
        .final_v (final_status),
        .any     (irq_out)
    );
endmodule

// File: rtl/gpio_irq_ctrl_checker.sv
module gpio_irq_ctrl_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] cfg_enable,
    input logic [NUM_PINS-1:0] cfg_mask,
    input logic [NUM_PINS-1:0] cfg_is_edge,
    input logic [NUM_PINS-1:0] cfg_polarity,
    input logic                cfg_level_sync,
    input logic [NUM_PINS-1:0] eoi_pulse,
    input logic [NUM_PINS-1:0] raw_status,
    input logic [NUM_PINS-1:0] final_status,
    input logic                irq_out
);
    logic [NUM_PINS-1:0] act_lvl;
    assign act_lvl = ~(pin_in ^ cfg_polarity);

    p_edge_needs_transition_r1: assert property (@(posedge clk) disable iff (rst)
        ((raw_status & ~$past(raw_status) & cfg_is_edge & $past(cfg_is_edge)
          & ~($past(pin_in) ^ $past(pin_in, 2))) == '0));

    p_edge_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (($past(raw_status & cfg_is_edge & ~eoi_pulse & cfg_enable)
          & cfg_enable & cfg_is_edge & ~raw_status) == '0));

    p_level_direct_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_level_sync |->
        (((raw_status ^ act_lvl) & cfg_enable & ~cfg_is_edge) == '0));

    p_level_sync_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_level_sync && !$past(rst)) |->
        (((raw_status ^ $past(act_lvl)) & cfg_enable & ~cfg_is_edge) == '0));

    p_disable_discards_r6: assert property (@(posedge clk) disable iff (rst)
        ((~$past(cfg_enable) & cfg_is_edge & raw_status) == '0));

    p_mask_only_final_r7: assert property (@(posedge clk) disable iff (rst)
        ($stable(raw_status) && $stable(cfg_mask)) |-> $stable(final_status));

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> !$stable(final_status));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk            (clk),
    .rst            (rst),
    .pin_in         (pin_in),
    .cfg_enable     (cfg_enable),
    .cfg_mask       (cfg_mask),
    .cfg_is_edge    (cfg_is_edge),
    .cfg_polarity   (cfg_polarity),
    .cfg_level_sync (cfg_level_sync),
    .eoi_pulse      (eoi_pulse),
    .raw_status     (raw_status),
    .final_status   (final_status),
    .irq_out        (irq_out)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] cfg_enable = '0;
    logic [NP-1:0] cfg_mask = '0;
    logic [NP-1:0] cfg_is_edge = '0;
    logic [NP-1:0] cfg_polarity = '0;
    logic          cfg_level_sync = 1'b0;
    logic [NP-1:0] eoi_pulse = '0;
    logic [NP-1:0] raw_status;
    logic [NP-1:0] final_status;
    logic          irq_out;

    // values applied at the next driven cycle
    logic          sh_rst = 1'b1;
    logic [NP-1:0] sh_en = '0, sh_mask = '0, sh_edge = '0, sh_pol = '0;
    logic          sh_sync = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [NP-1:0] raw;
        logic [NP-1:0] fin;
        logic          irq;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP)) dut (
        .clk            (clk),
        .rst            (rst),
        .pin_in         (pin_in),
        .cfg_enable     (cfg_enable),
        .cfg_mask       (cfg_mask),
        .cfg_is_edge    (cfg_is_edge),
        .cfg_polarity   (cfg_polarity),
        .cfg_level_sync (cfg_level_sync),
        .eoi_pulse      (eoi_pulse),
        .raw_status     (raw_status),
        .final_status   (final_status),
        .irq_out        (irq_out)
    );

    // one cycle of stimulus; expected final and irq follow R7 and R8
    task automatic cyc(input logic [NP-1:0] pins, input logic [NP-1:0] eoi_v,
                       input logic [NP-1:0] exp_raw, input string tag);
        exp_t e;
        @(negedge clk);
        rst            = sh_rst;
        cfg_enable     = sh_en;
        cfg_mask       = sh_mask;
        cfg_is_edge    = sh_edge;
        cfg_polarity   = sh_pol;
        cfg_level_sync = sh_sync;
        pin_in         = pins;
        eoi_pulse      = eoi_v;
        e.raw = exp_raw;
        e.fin = exp_raw & ~sh_mask;
        e.irq = |(exp_raw & ~sh_mask);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: mid-cycle sampling
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (raw_status !== e.raw) begin
                    errors++;
                    $display("FAIL %s raw_status got %h exp %h", e.tag, raw_status, e.raw);
                end
                checks++;
                if (final_status !== e.fin) begin
                    errors++;
                    $display("FAIL %s (R7) final_status got %h exp %h", e.tag, final_status, e.fin);
                end
                checks++;
                if (irq_out !== e.irq) begin
                    errors++;
                    $display("FAIL %s (R8) irq_out got %b exp %b", e.tag, irq_out, e.irq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired with %0d items pending", sb.size());
            summary();
            $finish;
        end
    end

    initial begin
        // reset state
        cyc(8'h00, 8'h00, 8'h00, "R9 reset state");
        sh_en = 8'hFF; sh_edge = 8'h0F; sh_pol = 8'h55;
        cyc(8'hFF, 8'h00, 8'h50, "R9 level under reset");
        sh_rst = 1'b0;
        cyc(8'hFF, 8'h00, 8'h50, "R9 first cycle out of reset");
        cyc(8'h00, 8'h00, 8'hA0, "R9 no spurious edge");
        cyc(8'h01, 8'h00, 8'hAA, "R1 falling edges pins 1 and 3");
        cyc(8'h01, 8'h02, 8'hAB, "R1 rising edge pin 0");
        cyc(8'h09, 8'h00, 8'hA9, "R2 eoi clears pin 1");
        cyc(8'h01, 8'h08, 8'hA9, "R1 wrong direction ignored");
        cyc(8'h01, 8'h09, 8'hA9, "R3 set beats eoi");
        cyc(8'h01, 8'hF0, 8'hA0, "R2 eoi clears pins 0 and 3");
        cyc(8'hF1, 8'h00, 8'h50, "R4 eoi ignored, level polarity");
        sh_mask = 8'h10;
        cyc(8'hF1, 8'h00, 8'h50, "R7 partial mask");
        sh_mask = 8'h50;
        cyc(8'hF1, 8'h00, 8'h50, "R8 all masked");
        sh_mask = 8'h00; sh_sync = 1'b1;
        cyc(8'h01, 8'h00, 8'h50, "R5 sync delays level");
        cyc(8'h01, 8'h00, 8'hA0, "R5 sync catches up");
        sh_sync = 1'b0;
        cyc(8'h00, 8'h00, 8'hA0, "R4 level direct again");
        cyc(8'h01, 8'h00, 8'hA0, "R1 before rise shows");
        cyc(8'h01, 8'h00, 8'hA1, "R1 rise pin 0");
        sh_en = 8'hFE;
        cyc(8'h01, 8'h00, 8'hA0, "R6 disabled pin reads 0");
        sh_en = 8'hFF;
        cyc(8'h01, 8'h00, 8'hA0, "R6 pending discarded");
        cyc(8'h00, 8'h00, 8'hA0, "R1 fall ignored for rising pin");
        cyc(8'h01, 8'h00, 8'hA0, "R1 rise again");
        sh_edge = 8'h0E;
        cyc(8'h01, 8'h00, 8'hA1, "R6 pin 0 as level");
        sh_edge = 8'h0F;
        cyc(8'h01, 8'h00, 8'hA0, "R6 type switch discards pending");
        cyc(8'h03, 8'h00, 8'hA0, "R1 rise on falling pin ignored");
        cyc(8'h01, 8'h00, 8'hA0, "R1 fall on pin 1");
        sh_rst = 1'b1;
        cyc(8'h01, 8'h00, 8'hA2, "R9 pending before reset edge");
        sh_rst = 1'b0; sh_sync = 1'b1;
        cyc(8'h01, 8'h00, 8'h00, "R9 reset cleared pending and sync flop");
        cyc(8'h01, 8'h00, 8'hA0, "R5 sync refills after reset");
        sh_sync = 1'b0;
        cyc(8'h01, 8'h00, 8'hA0, "R4 final idle cycle");
        wait (sb.size() == 0);
        @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule